// File: doc/BRIEF.md
# Serial ADC Read Sequencer

This block drives a serial analog-to-digital converter over a three-wire link: a serial clock `sclk`, a command line `din` toward the converter, a data line `dout` from it, and an active-low select `cs_n`. A one-cycle `start` pulse carrying a request byte begins one conversion frame. The frame shifts out an eight-bit command, gives five more clock pulses for the converter to acquire its input, then reads twelve result bits. The serial clock comes from a divider on the system clock, and its half period is taken from `div_half` when each frame begins.

A scan pulse reads a list held on `scan_list`. Byte 0 of the list holds a count, and bytes 1 to 8 hold channel requests. The block converts the listed channels in order and writes each result as a pair of bytes into a 16-byte output block through a simple write port. Any word slots not used are then written with zero, so the consumer always gets a whole block. `busy` tells a neighbour that shares the wires when the link is in use.

The frame engine has states FR_IDLE, FR_CMD, FR_ACQ, FR_RDHI, FR_RDLO and FR_TAIL. FR_IDLE goes to FR_CMD when a start is accepted. Each of the middle states moves on after the falling edge of its last pulse. FR_TAIL goes back to FR_IDLE after one half period, and `done` is raised at that point. The scan controller has states SC_IDLE, SC_LAUNCH, SC_WAIT, SC_WLO, SC_WHI, SC_FILL and SC_FIN:
- SC_IDLE goes to SC_LAUNCH, or to SC_FILL when the count is zero.
- SC_LAUNCH goes to SC_WAIT.
- SC_WAIT goes to SC_WLO when the frame reports done.
- SC_WLO goes to SC_WHI.
- SC_WHI goes back to SC_LAUNCH while channels remain. Otherwise it goes to SC_FILL, or to SC_FIN when the block is already full.
- SC_FILL goes to SC_FIN at the last address.
- SC_FIN goes to SC_IDLE and raises `scan_done`.

Top module: `adc_seq_top`

## Requirements
- R1: The command byte sent is the request with bits 7, 1 and 0 replaced: bit 7 = 1, bit 1 = 0, bit 0 = 1, bits 6:2 unchanged. It is sent MSB first over the first 8 `sclk` pulses and read by the converter on each rising edge.
- R2: `cs_n` is high while idle. It falls before the first rising edge of `sclk` and stays low for exactly 25 pulses. It rises only after the last read pulse has ended, and no `sclk` pulse occurs while it is high.
- R3: `din` never changes while `sclk` is high.
- R4: Pulses 9 to 13 of a frame are acquisition pulses, and `din` is 0 during all of them.
- R5: Pulses 14 to 25 read the result. `dout` is sampled as each of these pulses falls. The first 4 samples form `result[11:8]` and the next 8 form `result[7:0]`, MSB first.
- R6: Every high and low phase of `sclk` lasts max(`div_half`, 2) system cycles. `div_half` is sampled only when a frame starts, so a change during a frame has no effect.
- R7: `start` is accepted only while `busy` is low, and a start during a frame is ignored. Each frame ends with a one-cycle `done`, with `result` valid and `busy` low in that cycle.
- R8: A scan takes its count from `scan_list[7:0]`, and a count above 8 is treated as 8. It converts entries 1..count in order. Entry k's result goes to byte address 2(k-1) as `result[7:0]`, then on the next cycle to 2(k-1)+1 as {4'b0, `result[11:8]`}.
- R9: After the last conversion, a scan writes zero to every remaining address up to 15, so each scan writes exactly 16 bytes. It then pulses `scan_done` for one cycle. A count of 0 writes 16 zero bytes and runs no frame.
- R10: If `scan_start` and `start` arrive in the same idle cycle, the scan wins and the single request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-conversion request pulse |
| req_chan | input | 8 | Request byte for a single conversion |
| scan_start | input | 1 | Scan request pulse |
| scan_list | input | 72 | Byte 0 = count, bytes 1..8 = channel requests |
| div_half | input | 8 | `sclk` half period in system cycles (minimum 2) |
| sclk | output | 1 | Serial clock to the converter |
| din | output | 1 | Command data to the converter |
| dout | input | 1 | Result data from the converter |
| cs_n | output | 1 | Active-low converter select |
| busy | output | 1 | A frame or scan is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| result | output | 12 | Last converted value |
| buf_we | output | 1 | Output block write strobe |
| buf_addr | output | 4 | Output block byte address |
| buf_data | output | 8 | Output block byte |
| scan_done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The hardest conditions to reach are the rejected requests: a start that arrives in the middle of a frame, and a start that lands in the same cycle as a scan request. Neither leaves a trace unless the bench proves that no extra frame, done pulse or buffer write followed. To cover the first, the bench fires a start with a different channel, and a new divider value, 30 cycles into a running frame. It then checks that the frame's command byte and clock width stay as planned and that no further done appears. To cover the second, the bench asserts both request lines together. It then checks that exactly the listed scan frames ran and that each one ended in a scored done pulse.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;
    localparam int CMD_BITS = 8;
    localparam int ACQ_CLKS = 5;
    localparam int HI_BITS  = 4;
    localparam int LO_BITS  = 8;
    localparam int RES_W    = HI_BITS + LO_BITS;
    localparam int CNT_W    = 4;

    typedef enum logic [2:0] {
        FR_IDLE, FR_CMD, FR_ACQ, FR_RDHI, FR_RDLO, FR_TAIL
    } frame_st_e;

    typedef enum logic [2:0] {
        SC_IDLE, SC_LAUNCH, SC_WAIT, SC_WLO, SC_WHI, SC_FILL, SC_FIN
    } scan_st_e;

    // Keep channel/gain/polarity, force start bit and external-clock bit.
    function automatic logic [7:0] make_ctrl(input logic [7:0] req);
        make_ctrl = (req & 8'b0111_1100) | 8'b1000_0001;
    endfunction
endpackage

// File: rtl/adcseq_clkdiv.sv
`timescale 1ns/1ps
module adcseq_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= MIN_HALF;
            cnt_q  <= '0;
        end else if (load) begin
            half_q <= (div_in < MIN_HALF) ? MIN_HALF : div_in;
            cnt_q  <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // R6
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/adcseq_frame.sv
`timescale 1ns/1ps
module adcseq_frame
    import adcseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       req,
    input  logic             tick,
    input  logic             dout,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             sclk,
    output logic             din,
    output logic             cs_n
);
    frame_st_e st_q, st_d;

    logic             ph_q;
    logic [CNT_W-1:0] bit_q;
    logic [7:0]       sh_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] res_q;
    logic             done_q;
    logic             fall;
    logic             last;

    assign fall = tick && ph_q;

    always_comb begin
        unique case (st_q)
            FR_CMD:  last = (bit_q == CNT_W'(CMD_BITS - 1));
            FR_ACQ:  last = (bit_q == CNT_W'(ACQ_CLKS - 1));
            FR_RDHI: last = (bit_q == CNT_W'(HI_BITS - 1));
            FR_RDLO: last = (bit_q == CNT_W'(LO_BITS - 1));
            default: last = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE: if (go)           st_d = FR_CMD;
            FR_CMD:  if (fall && last) st_d = FR_ACQ;
            FR_ACQ:  if (fall && last) st_d = FR_RDHI;
            FR_RDHI: if (fall && last) st_d = FR_RDLO;
            FR_RDLO: if (fall && last) st_d = FR_TAIL;
            FR_TAIL: if (tick)         st_d = FR_IDLE;
            default:                   st_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= 1'b0;
            bit_q  <= '0;
            sh_q   <= '0;
            acc_q  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (st_q == FR_TAIL) && tick;
            if (st_q == FR_IDLE) begin
                ph_q  <= 1'b0;
                bit_q <= '0;
                if (go) begin
                    sh_q  <= make_ctrl(req);
                    acc_q <= '0;
                end
            end else if (st_q == FR_TAIL) begin
                if (tick) res_q <= acc_q;
            end else if (tick) begin
                if (!ph_q) begin
                    ph_q <= 1'b1;
                end else begin
                    ph_q  <= 1'b0;
                    bit_q <= last ? '0 : bit_q + 1'b1;
                    if (st_q == FR_CMD)
                        sh_q <= {sh_q[6:0], 1'b0};
                    if (st_q == FR_RDHI || st_q == FR_RDLO)
                        acc_q <= {acc_q[RES_W-2:0], dout};
                end
            end
        end
    end

    always_comb begin
        busy   = (st_q != FR_IDLE);
        cs_n   = (st_q == FR_IDLE);
        sclk   = ph_q;
        din    = (st_q == FR_CMD) ? sh_q[7] : 1'b0;
        done   = done_q;
        result = res_q;
    end

    // R2
    sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    // R3
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(din));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/adcseq_scan.sv
`timescale 1ns/1ps
module adcseq_scan
    import adcseq_pkg::*;
#(
    parameter int LIST_DEPTH = 8,
    parameter int ADDR_W     = 4,
    parameter int IDX_W      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic [(LIST_DEPTH+1)*8-1:0] list_in,
    input  logic                      fr_done,
    input  logic [RES_W-1:0]          fr_result,
    output logic                      launch,
    output logic [7:0]                chan,
    output logic                      busy,
    output logic                      buf_we,
    output logic [ADDR_W-1:0]         buf_addr,
    output logic [7:0]                buf_data,
    output logic                      scan_done
);
    localparam int               LIST_W    = (LIST_DEPTH + 1) * 8;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(2 * LIST_DEPTH - 1);

    scan_st_e st_q, st_d;

    logic [LIST_W-1:0] list_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [RES_W-1:0]  res_q;
    logic [IDX_W-1:0]  cnt_clamp;

    always_comb begin
        if (list_in[7:0] > 8'(LIST_DEPTH)) cnt_clamp = IDX_W'(LIST_DEPTH);
        else                               cnt_clamp = list_in[IDX_W-1:0];
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SC_IDLE:   if (go) st_d = (cnt_clamp == '0) ? SC_FILL : SC_LAUNCH;
            SC_LAUNCH: st_d = SC_WAIT;
            SC_WAIT:   if (fr_done) st_d = SC_WLO;
            SC_WLO:    st_d = SC_WHI;
            SC_WHI: begin
                if (idx_q != cnt_q)          st_d = SC_LAUNCH;
                else if (waddr_q == LAST_ADDR) st_d = SC_FIN;
                else                         st_d = SC_FILL;
            end
            SC_FILL:   if (waddr_q == LAST_ADDR) st_d = SC_FIN;
            SC_FIN:    st_d = SC_IDLE;
            default:   st_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SC_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            waddr_q <= '0;
            res_q   <= '0;
        end else begin
            unique case (st_q)
                SC_IDLE: if (go) begin
                    list_q  <= list_in;
                    cnt_q   <= cnt_clamp;
                    idx_q   <= IDX_W'(1);
                    waddr_q <= '0;
                end
                SC_WAIT: if (fr_done) res_q <= fr_result;
                SC_WLO:  waddr_q <= waddr_q + 1'b1;
                SC_WHI: begin
                    waddr_q <= waddr_q + 1'b1;
                    if (idx_q != cnt_q) idx_q <= idx_q + 1'b1;
                end
                SC_FILL: waddr_q <= waddr_q + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        launch    = (st_q == SC_LAUNCH);
        chan      = list_q[{idx_q, 3'b000} +: 8];
        busy      = (st_q != SC_IDLE);
        buf_we    = (st_q == SC_WLO) || (st_q == SC_WHI) || (st_q == SC_FILL);
        buf_addr  = waddr_q;
        scan_done = (st_q == SC_FIN);
        unique case (st_q)
            SC_WLO:  buf_data = res_q[7:0];
            SC_WHI:  buf_data = {{(16-RES_W){1'b0}}, res_q[RES_W-1:8]};
            default: buf_data = 8'h00;
        endcase
    end

    // R8
    hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_addr[0]) |-> ($past(buf_we) && (ADDR_W'($past(buf_addr) + 1'b1) == buf_addr)));
    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> ($past(buf_we) && ($past(buf_addr) == LAST_ADDR)));
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
    import adcseq_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int LIST_DEPTH = 8,
    localparam int ADDR_W    = $clog2(2 * LIST_DEPTH),
    localparam int IDX_W     = $clog2(LIST_DEPTH + 1),
    localparam int LIST_W    = (LIST_DEPTH + 1) * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        req_chan,
    input  logic              scan_start,
    input  logic [LIST_W-1:0] scan_list,
    input  logic [DIV_W-1:0]  div_half,
    output logic              sclk,
    output logic              din,
    input  logic              dout,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic [RES_W-1:0]  result,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              scan_done
);
    logic       fr_busy, sc_busy;
    logic       scan_go, single_go;
    logic       sc_launch;
    logic [7:0] sc_chan;
    logic       fr_go;
    logic [7:0] fr_req;
    logic       tick;

    assign busy      = fr_busy || sc_busy;
    assign scan_go   = scan_start && !busy;
    assign single_go = start && !busy && !scan_start;
    assign fr_go     = single_go || sc_launch;
    assign fr_req    = sc_launch ? sc_chan : req_chan;

    adcseq_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (fr_go),
        .run    (fr_busy),
        .div_in (div_half),
        .tick   (tick)
    );

    adcseq_frame u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (fr_go),
        .req    (fr_req),
        .tick   (tick),
        .dout   (dout),
        .busy   (fr_busy),
        .done   (done),
        .result (result),
        .sclk   (sclk),
        .din    (din),
        .cs_n   (cs_n)
    );

    adcseq_scan #(
        .LIST_DEPTH (LIST_DEPTH),
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (scan_go),
        .list_in   (scan_list),
        .fr_done   (done),
        .fr_result (result),
        .launch    (sc_launch),
        .chan      (sc_chan),
        .busy      (sc_busy),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .scan_done (scan_done)
    );

    // R7
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_go |-> !fr_busy);
endmodule

// File: tb/adc_seq_top_bench.sv
`timescale 1ns/1ps
module adc_seq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start, scan_start;
    logic [7:0]  req_chan;
    logic [71:0] scan_list;
    logic [7:0]  div_half;
    logic        sclk, din, cs_n, busy, done, buf_we, scan_done;
    logic        dout = 1'b0;
    logic [11:0] result;
    logic [3:0]  buf_addr;
    logic [7:0]  buf_data;

    always #2.5 clk = ~clk;

    adc_seq_top u_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .req_chan(req_chan),
        .scan_start(scan_start), .scan_list(scan_list), .div_half(div_half),
        .sclk(sclk), .din(din), .dout(dout), .cs_n(cs_n), .busy(busy),
        .done(done), .result(result), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_data(buf_data), .scan_done(scan_done)
    );

    typedef struct { logic [7:0] c; int h; } exp_t;
    exp_t exp_q[$];

    int checks = 0, fails = 0;
    bit ended = 0;

    function automatic logic [11:0] fmodel(logic [7:0] c);
        return 12'((int'(c) * 29 + 1234) % 4096);
    endfunction
    function automatic logic [7:0] exp_ctrl(logic [7:0] r);
        return {1'b1, r[6:2], 2'b01};
    endfunction
    function automatic int exp_half(int d);
        return (d < 2) ? 2 : d;
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Converter model
    int          sl_n = 0, sl_end_pulses = 0, stray_clk = 0;
    logic [7:0]  sl_sh = 0, sl_ctrl = 0;
    logic [11:0] sl_data = 0;
    bit          sl_acq_bad = 0;

    always @(negedge cs_n) begin sl_n = 0; sl_acq_bad = 0; end
    always @(posedge cs_n) sl_end_pulses = sl_n;
    always @(posedge sclk) begin
        if (cs_n) stray_clk++;
        sl_n++;
        if (sl_n <= 8) begin
            sl_sh = {sl_sh[6:0], din};
            if (sl_n == 8) begin sl_ctrl = sl_sh; sl_data = fmodel(sl_sh); end
        end else if (sl_n <= 13) begin
            if (din) sl_acq_bad = 1;
        end else if (sl_n <= 25) begin
            dout = sl_data[25 - sl_n];
        end
    end

    // Waveform statistics
    int   hi_run = 0, hi_min = 1000000, hi_max = 0, din_hi_chg = 0;
    logic prev_sclk = 0, prev_din = 0, prev_cs = 1;
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin hi_min = 1000000; hi_max = 0; end
        if (sclk) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (sclk && prev_sclk && (din !== prev_din)) din_hi_chg++;
        prev_sclk = sclk; prev_din = din; prev_cs = cs_n;
    end

    // Scoreboard monitor
    int         done_seen = 0, we_seen = 0;
    logic [7:0] mem [16];
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin mem[buf_addr] = buf_data; we_seen++; end
            if (done) begin
                done_seen++;
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "done without accepted start", result, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(sl_ctrl == e.c, "R1", "command byte", sl_ctrl, e.c);
                    chk(result == fmodel(e.c), "R5", "result", result, fmodel(e.c));
                    chk(sl_end_pulses == 25, "R2", "pulses under select", sl_end_pulses, 25);
                    chk(!sl_acq_bad, "R4", "din high in acquisition", sl_acq_bad, 0);
                    chk(hi_min == e.h && hi_max == e.h, "R6", "sclk high width", hi_max, e.h);
                    chk(din_hi_chg == 0, "R3", "din moved while sclk high", din_hi_chg, 0);
                end
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic single(logic [7:0] r, int d);
        wait_idle();
        exp_q.push_back('{exp_ctrl(r), exp_half(d)});
        req_chan = r; div_half = 8'(d); start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic scan(int count, logic [7:0] chs [8], int d, bit with_single);
        int n, d0;
        logic [11:0] v;
        logic [7:0] ev;
        wait_idle();
        n = (count > 8) ? 8 : count;
        for (int i = 0; i < n; i++) exp_q.push_back('{exp_ctrl(chs[i]), exp_half(d)});
        for (int i = 0; i < 16; i++) mem[i] = 8'hAA;
        we_seen = 0; d0 = done_seen;
        scan_list[7:0] = 8'(count);
        for (int i = 0; i < 8; i++) scan_list[8*(i+1) +: 8] = chs[i];
        div_half = 8'(d); scan_start = 1;
        if (with_single) begin start = 1; req_chan = 8'h3C; end
        @(negedge clk);
        scan_start = 0; start = 0;
        do @(negedge clk); while (!scan_done);
        for (int i = 0; i < 16; i++) begin
            if (i / 2 < n) begin
                v  = fmodel(exp_ctrl(chs[i/2]));
                ev = (i % 2 == 0) ? v[7:0] : {4'h0, v[11:8]};
                chk(mem[i] === ev, "R8", "buffer byte", mem[i], ev);
            end else begin
                chk(mem[i] === 8'h00, "R9", "zero fill byte", mem[i], 0);
            end
        end
        chk(we_seen == 16, "R9", "bytes written per scan", we_seen, 16);
        chk(done_seen - d0 == n, with_single ? "R10" : "R8", "frames in scan", done_seen - d0, n);
        chk(exp_q.size() == 0, "R8", "pending expected frames", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            checks++; fails++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            report();
        end
    end

    initial begin
        start = 0; scan_start = 0; req_chan = 0; div_half = 2; scan_list = 0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R2", "cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0 && busy == 1'b0 && done == 1'b0 && buf_we == 1'b0, "R7",
            "outputs in reset", {sclk, busy, done, buf_we}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0, "R2", "idle after reset", {cs_n, busy}, 2);

        single(8'hFF, 2);
        single(8'h00, 3);
        single(8'hA6, 1);
        single(8'h5B, 4);
        // R7 start during a frame is dropped; R6 divider change mid-frame ignored
        repeat (30) @(negedge clk);
        req_chan = 8'h10; div_half = 8'd7; start = 1;
        @(negedge clk);
        start = 0;
        wait_idle();
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R7", "idle after dropped start", {busy, cs_n}, 1);
        chk(done_seen == 4, "R7", "frames after dropped start", done_seen, 4);

        scan(3, '{8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 2, 0);
        scan(12, '{8'h04, 8'h08, 8'h0C, 8'h7C, 8'hFF, 8'h80, 8'h40, 8'h20}, 3, 0);
        scan(0, '{8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44}, 2, 0);
        scan(1, '{8'h55, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 2, 1);

        repeat (20) @(negedge clk);
        chk(stray_clk == 0, "R2", "sclk pulses with cs_n high", stray_clk, 0);
        chk(exp_q.size() == 0 && busy == 1'b0, "R10", "no dropped request ran", exp_q.size(), 0);
        report();
    end
endmodule